// File: doc/BRIEF.md
# Bus-Cycle Interrupt Timer

This block is an interrupt source for a cartridge attached to an 8-bit CPU bus. It counts rising edges of the CPU's bus-cycle strobe (M2) and pulls an active-low interrupt line to the CPU once a fixed number of bus cycles has passed. Software controls it through one write-only control register that the block decodes from the full CPU address. The block sees only the address, the three low data bits, the read/write line and M2.

A write of the one enable code starts the count from zero. A write of any other code stops the timer, clears the count and withdraws a pending interrupt, which is how software acknowledges it. If software leaves an interrupt unanswered, the timer withdraws it by itself after a second interval of the same length. It stays enabled and begins a new interval. Every input is sampled on the fast system clock `clk`. M2 edges are found by comparing each sample with the one before it.

Top module: `cyc_irq_timer`

## Requirements
- R1: While `rst_n` is low, `irq_n` is high at once. After reset the timer is disabled, and `irq_n` stays high for any number of M2 edges until the enable code is written.
- R2: A control write is taken only on the `clk` edge where M2 is seen falling, with `cpu_rw` = 0 and `cpu_addr` = 16'h4122. Writes to any other address, and reads of 16'h4122, have no effect on `irq_n` or on the count.
- R3: Writing data 3'd3 to a disabled timer enables it. The count starts from zero, so the first M2 rising edge after the write is edge 1.
- R4: When enabled, `irq_n` goes low on the `clk` edge that sees the 4096th M2 rising edge after enabling.
- R5: An unacknowledged interrupt is withdrawn (`irq_n` high) on the 4096th M2 rising edge after it was raised. The timer stays enabled and raises `irq_n` low again after a further 4096 rising edges.
- R6: Writing any value other than 3'd3 (0, 1, 2, 4, 5, 6, 7) disables the timer, clears the count and sets `irq_n` high. `irq_n` then stays high for any number of M2 edges.
- R7: Writing 3'd3 while the timer is already enabled changes neither the count nor `irq_n`.
- R8: Only rising edges of M2 are counted. M2 held high for many `clk` cycles counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 3 | CPU data bits 2..0 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| m2 | input | 1 | CPU bus-cycle strobe, sampled on `clk` |
| irq_n | output | 1 | Active-low interrupt request to the CPU |

## Verification
A wrong count or a wrong phase bit stays invisible until the next interval boundary. It then shows as `irq_n` moving on the wrong edge, which can be up to 4096 M2 edges after the fault. For that reason the bench checks `irq_n` against its own model on every clock, and it places named checks on the edges just before and just after each boundary. A stale enable or a stale pending flag shows right after a control write or a reset: `irq_n` stays low, or a boundary that should not come does come. The bench therefore runs more than a full interval after each disable to catch it.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'h4122;
  localparam logic [DATA_W-1:0] RUN_CODE  = 3'd3;

  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/cyc_irq_edge.sv
module cyc_irq_edge
  import cyc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       m2,
  output strobe_ev_t ev
);
  logic m2_q, m2_d;

  always_comb begin
    m2_d    = m2;
    ev.rise = m2 & ~m2_q;
    ev.fall = ~m2 & m2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m2_q <= 1'b0;
    else        m2_q <= m2_d;
  end

  // R8
  rise_needs_low_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rise |=> !ev.rise);
endmodule

// File: rtl/cyc_irq_ctrl.sv
module cyc_irq_ctrl
  import cyc_irq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter logic [AW-1:0] REG_ADDR = CTRL_ADDR,
  parameter logic [DW-1:0] GO_CODE  = RUN_CODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_ev_t    ev,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          cpu_rw,
  output logic          run_q,
  output logic          stop_pulse
);
  logic wr_hit, run_d, run_ce;

  always_comb begin
    wr_hit     = ev.fall & ~cpu_rw & (cpu_addr == REG_ADDR);
    run_ce     = wr_hit;
    run_d      = (cpu_data == GO_CODE);
    stop_pulse = wr_hit & (cpu_data != GO_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_ce) run_q <= run_d;
  end

  // R2
  run_change_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != $past(run_q)) |-> $past(ev.fall && !cpu_rw && cpu_addr == REG_ADDR));
endmodule

// File: rtl/cyc_irq_count.sv
module cyc_irq_count #(
  parameter int unsigned CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_q,
  input  logic stop_pulse,
  input  logic tick,
  output logic pend_q
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d, pend_d, ce;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    pend_d  = pend_q;
    ce      = 1'b0;
    if (stop_pulse || !run_q) begin
      ce      = 1'b1;
      cnt_d   = '0;
      phase_d = 1'b0;
      pend_d  = 1'b0;
    end else if (tick) begin
      ce    = 1'b1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        phase_d = ~phase_q;
        pend_d  = ~phase_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (ce) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      pend_q  <= pend_d;
    end
  end

  // R6
  idle_is_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0 && !pend_q));
  // R4
  raise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(tick && run_q));
  // R5
  self_release_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pend_q) && run_q) |-> ($past(tick) && $past(run_q)));
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned CNT_W = 12,
  parameter logic [AW-1:0] REG_ADDR = CTRL_ADDR,
  parameter logic [DW-1:0] GO_CODE  = RUN_CODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          cpu_rw,
  input  logic          m2,
  output logic          irq_n
);
  logic [1:0] rs_q;
  logic       srst_n, run_q, stop_pulse, pend_q;
  strobe_ev_t ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  cyc_irq_edge u_edge (.clk(clk), .rst_n(srst_n), .m2(m2), .ev(ev));

  cyc_irq_ctrl #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR), .GO_CODE(GO_CODE)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .ev(ev), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .run_q(run_q), .stop_pulse(stop_pulse));

  cyc_irq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .run_q(run_q), .stop_pulse(stop_pulse),
    .tick(ev.rise), .pend_q(pend_q));

  assign irq_n = ~pend_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !srst_n |-> irq_n);
endmodule

// File: tb/test_cyc_irq_timer.sv
module test_cyc_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [2:0]  cpu_data = 3'd0;
  logic        cpu_rw = 1'b1;
  logic        m2 = 1'b0;
  logic        irq_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference
  bit m_run, m_ph, m_pend, m_pm2;
  int m_cnt;

  cyc_irq_timer i_cyc_irq_timer (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_rw(cpu_rw), .m2(m2), .irq_n(irq_n));

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: irq_n=%b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_pend = 0; m_pm2 = 0; m_cnt = 0;
    end else begin
      cyc++;
      if (!m2 && m_pm2 && !cpu_rw && cpu_addr == 16'h4122) begin
        if (cpu_data == 3'd3) m_run = 1;
        else begin m_run = 0; m_cnt = 0; m_ph = 0; m_pend = 0; end
      end else if (m_run && m2 && !m_pm2) begin
        m_cnt++;
        if (m_cnt == 4096) begin
          m_cnt = 0; m_pend = !m_ph; m_ph = !m_ph;
        end
      end
      m_pm2 = m2;
    end
  end

  always @(negedge clk) if (rst_n && !done) check("R4/R5 model", irq_n, !m_pend);

  task automatic bus(input logic [15:0] a, input logic rw, input logic [2:0] d);
    cpu_addr = a; cpu_rw = rw; cpu_data = d; m2 = 1'b1;
    @(negedge clk);
    m2 = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus(16'h0000, 1'b1, 3'd0);
  endtask

  task automatic long_high(input int n);
    cpu_addr = 16'h0000; cpu_rw = 1'b1; m2 = 1'b1;
    repeat (n) @(negedge clk);
    m2 = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1 check("R1 reset asserted", irq_n, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    @(negedge clk); #1;
    check("R1 in reset", irq_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(4200);
    check("R1 disabled after reset", irq_n, 1'b1);
    // R3/R4 first interval
    bus(16'h4122, 1'b0, 3'd3);
    idle(4095); check("R4 before boundary", irq_n, 1'b1);
    idle(1);    check("R4 raised", irq_n, 1'b0);
    // R5 self release and re-raise
    idle(4095); check("R5 still pending", irq_n, 1'b0);
    idle(1);    check("R5 released", irq_n, 1'b1);
    idle(4095); check("R5 before re-raise", irq_n, 1'b1);
    idle(1);    check("R5 re-raised", irq_n, 1'b0);
    // R6 acknowledge by writing 5
    bus(16'h4122, 1'b0, 3'd5); check("R6 ack", irq_n, 1'b1);
    idle(4200); check("R6 stays quiet", irq_n, 1'b1);
    // R2 wrong address and read are ignored
    bus(16'h4123, 1'b0, 3'd3);
    bus(16'h4122, 1'b1, 3'd3);
    bus(16'h0122, 1'b0, 3'd3);
    idle(4200); check("R2 ignored accesses", irq_n, 1'b1);
    // R7 and R8: rewrite 3 and a long M2 high inside one interval
    bus(16'h4122, 1'b0, 3'd3);
    idle(1999);
    long_high(60);
    bus(16'h4122, 1'b0, 3'd3);
    idle(2094); check("R7 R8 before boundary", irq_n, 1'b1);
    idle(1);    check("R7 R8 raised on count", irq_n, 1'b0);
    // R6 other codes, R3 restart from zero
    bus(16'h4122, 1'b0, 3'd0); check("R6 code 0 ack", irq_n, 1'b1);
    bus(16'h4122, 1'b0, 3'd3);
    idle(3000);
    bus(16'h4122, 1'b0, 3'd7); check("R6 code 7", irq_n, 1'b1);
    bus(16'h4122, 1'b0, 3'd3);
    idle(4095); check("R3 restart not early", irq_n, 1'b1);
    idle(1);    check("R3 restart from zero", irq_n, 1'b0);
    // R1 reset mid-pending
    do_reset();
    check("R1 after reset", irq_n, 1'b1);
    idle(4200); check("R1 disabled by reset", irq_n, 1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    done = 1;
    checks++; failures++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule